// File: doc/BRIEF.md
# Scalar Double Move and Merge Unit

This unit performs the scalar 64-bit floating-point move family on wide vector registers. A decoder upstream supplies the encoding class, the operand form, the old destination register value, two register sources, a 64-bit memory datum and the masking controls. One cycle later the unit returns either a complete new register value with a write enable, or a 64-bit store datum with a store enable. An illegal combination raises an invalid-opcode flag instead.

The encoding class decides what happens to the bits above the low lane. The base class preserves the upper register contents. The non-destructive-source class and the masked class clear bits that the operation does not define. Only the masked class applies the per-lane predicate, and it does so on the low 64-bit lane alone. Values are copied as raw bit patterns. No arithmetic is done, so no floating-point exception can arise.

Top module: `msm_unit`

## Requirements
- R1: Base class (enc=0) with register form (form=0): result bits 63:0 equal src2[63:0], and every bit from 64 upward equals old_dst.
- R2: Base class with load form (form=1): bits 63:0 equal mem_in, bits 127:64 are zero, and bits from 128 upward equal old_dst.
- R3: Non-destructive class (enc=1) and masked class (enc=2) with register form: bits 63:0 come from src2, bits 127:64 come from src1, and all higher bits are zero.
- R4: Non-destructive and masked classes with load form: bits 63:0 equal mem_in and every higher bit is zero.
- R5: In the masked class, the low lane takes the new value when k0=1 or mask_en=0. Otherwise it keeps old_dst[63:0] if zero_mask=0, or becomes zero if zero_mask=1. In classes 0 and 1, mask_en, k0 and zero_mask have no effect.
- R6: Store form (form=2) raises st_en with st_data=src2[63:0] and never raises reg_we. A masked-class store with mask_en=1 and k0=0 keeps st_en low, whatever the value of zero_mask.
- R7: In classes 1 and 2, the load and store forms require idx_field to be all ones. Any other value raises illegal. The base class ignores idx_field.
- R8: Form 3 (memory to memory) and class 3 (reserved) always raise illegal.
- R9: When illegal is high, reg_we and st_en are both low.
- R10: out_valid is high in exactly the cycle after a cycle with in_valid high, so back-to-back operations each produce a result.
- R11: Synchronous active-high reset clears out_valid, reg_we, st_en and illegal.
- R12: Bit patterns are passed through unchanged, including NaN payloads and sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| enc | input | 2 | Encoding class: 0 base, 1 non-destructive, 2 masked, 3 reserved |
| form | input | 2 | Operand form: 0 register, 1 load, 2 store, 3 memory to memory |
| old_dst | input | VLEN | Current destination register value |
| src1 | input | VLEN | First source, supplies bits 127:64 in merge forms |
| src2 | input | VLEN | Second source, supplies the low lane and the store datum |
| mem_in | input | LANE | Memory datum for load forms |
| mask_en | input | 1 | A predicate register is applied |
| k0 | input | 1 | Predicate bit for the low lane |
| zero_mask | input | 1 | 1 means zeroing masking, 0 means merging masking |
| idx_field | input | IDXW | Extra register index field |
| out_valid | output | 1 | Result valid |
| reg_we | output | 1 | Register write enable |
| reg_data | output | VLEN | New register value |
| st_en | output | 1 | Memory store enable |
| st_data | output | LANE | Store datum |
| illegal | output | 1 | Invalid-opcode flag |

## Verification
The bench works through every class and form pair, watching the boundary bits 63/64 and 127/128. A unit that mixed up the upper-bit policy would either leak old_dst into cleared bits or wipe preserved ones. The masked cases cover merge, zero and "no mask" for loads, register moves and stores. A design that applied zeroing to stores, or applied the predicate outside the masked class, would write memory or change the low lane when it should not. Two further cases probe gating and timing. Illegal index fields and forms must suppress both enables, so a design that only flagged the fault would still write. Back-to-back issue would expose a design that drops or delays a result.

// File: rtl/msm_pkg.sv
package msm_pkg;
  typedef enum logic [1:0] {
    ENC_BASE   = 2'd0,
    ENC_NDS    = 2'd1,
    ENC_MASKED = 2'd2,
    ENC_RSVD   = 2'd3
  } enc_e;

  typedef enum logic [1:0] {
    FORM_RR    = 2'd0,
    FORM_LOAD  = 2'd1,
    FORM_STORE = 2'd2,
    FORM_MM    = 2'd3
  } form_e;

  typedef struct packed {
    logic illegal;
    logic wr_reg;
    logic wr_mem;
  } ctl_t;
endpackage

// File: rtl/msm_decode.sv
module msm_decode
  import msm_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  enc_e            enc,
  input  form_e           form,
  input  logic [IDXW-1:0] idx_field,
  input  logic            mask_en,
  input  logic            k0,
  output ctl_t            ctl
);
  logic mem_form;
  logic idx_bad;
  logic pred_off;

  always_comb begin
    mem_form    = (form == FORM_LOAD) || (form == FORM_STORE);
    idx_bad     = (enc != ENC_BASE) && mem_form && (idx_field != {IDXW{1'b1}});
    pred_off    = (enc == ENC_MASKED) && mask_en && !k0;
    ctl.illegal = (enc == ENC_RSVD) || (form == FORM_MM) || idx_bad;
    ctl.wr_reg  = !ctl.illegal && ((form == FORM_RR) || (form == FORM_LOAD));
    ctl.wr_mem  = !ctl.illegal && (form == FORM_STORE) && !pred_off;
  end
endmodule

// File: rtl/msm_low_lane.sv
module msm_low_lane
  import msm_pkg::*;
#(
  parameter int LANE = 64
) (
  input  enc_e            enc,
  input  form_e           form,
  input  logic [LANE-1:0] old_lo,
  input  logic [LANE-1:0] src_lo,
  input  logic [LANE-1:0] mem_lo,
  input  logic            mask_en,
  input  logic            k0,
  input  logic            zero_mask,
  output logic [LANE-1:0] lo
);
  logic [LANE-1:0] fresh;

  always_comb begin
    fresh = (form == FORM_LOAD) ? mem_lo : src_lo;
    if ((enc == ENC_MASKED) && mask_en && !k0)
      lo = zero_mask ? '0 : old_lo;
    else
      lo = fresh;
  end
endmodule

// File: rtl/msm_upper.sv
module msm_upper
  import msm_pkg::*;
#(
  parameter int VLEN = 512,
  parameter int LANE = 64
) (
  input  enc_e                 enc,
  input  form_e                form,
  input  logic [VLEN-1:0]      old_dst,
  input  logic [VLEN-1:0]      src1,
  output logic [VLEN-LANE-1:0] hi
);
  localparam int NLANE = VLEN / LANE;

  logic keep_old;
  assign keep_old = (enc == ENC_BASE);

  for (genvar g = 1; g < NLANE; g++) begin : g_lane
    logic [LANE-1:0] v;
    if (g == 1) begin : g_second
      always_comb begin
        if (keep_old)
          v = (form == FORM_LOAD) ? '0 : old_dst[g*LANE +: LANE];
        else
          v = (form == FORM_RR) ? src1[g*LANE +: LANE] : '0;
      end
    end else begin : g_rest
      always_comb begin
        v = keep_old ? old_dst[g*LANE +: LANE] : '0;
      end
    end
    assign hi[(g-1)*LANE +: LANE] = v;
  end
endmodule

// File: rtl/msm_unit.sv
module msm_unit
  import msm_pkg::*;
#(
  parameter int VLEN = 512,
  parameter int LANE = 64,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      enc,
  input  logic [1:0]      form,
  input  logic [VLEN-1:0] old_dst,
  input  logic [VLEN-1:0] src1,
  input  logic [VLEN-1:0] src2,
  input  logic [LANE-1:0] mem_in,
  input  logic            mask_en,
  input  logic            k0,
  input  logic            zero_mask,
  input  logic [IDXW-1:0] idx_field,
  output logic            out_valid,
  output logic            reg_we,
  output logic [VLEN-1:0] reg_data,
  output logic            st_en,
  output logic [LANE-1:0] st_data,
  output logic            illegal
);
  enc_e                 enc_t;
  form_e                form_t;
  ctl_t                 ctl;
  logic [LANE-1:0]      lo;
  logic [VLEN-LANE-1:0] hi;

  assign enc_t  = enc_e'(enc);
  assign form_t = form_e'(form);

  msm_decode #(.IDXW(IDXW)) u_dec (
    .enc(enc_t), .form(form_t), .idx_field(idx_field),
    .mask_en(mask_en), .k0(k0), .ctl(ctl)
  );

  msm_low_lane #(.LANE(LANE)) u_lo (
    .enc(enc_t), .form(form_t), .old_lo(old_dst[LANE-1:0]),
    .src_lo(src2[LANE-1:0]), .mem_lo(mem_in), .mask_en(mask_en),
    .k0(k0), .zero_mask(zero_mask), .lo(lo)
  );

  msm_upper #(.VLEN(VLEN), .LANE(LANE)) u_hi (
    .enc(enc_t), .form(form_t), .old_dst(old_dst), .src1(src1), .hi(hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      reg_we    <= 1'b0;
      st_en     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      reg_we    <= in_valid && ctl.wr_reg;
      st_en     <= in_valid && ctl.wr_mem;
      illegal   <= in_valid && ctl.illegal;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      reg_data <= {hi, lo};
      st_data  <= src2[LANE-1:0];
    end
  end
endmodule

// File: rtl/msm_unit_chk.sv
module msm_unit_chk #(
  parameter int VLEN = 512,
  parameter int LANE = 64,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      enc,
  input logic [1:0]      form,
  input logic [VLEN-1:0] old_dst,
  input logic            mask_en,
  input logic            k0,
  input logic            zero_mask,
  input logic            out_valid,
  input logic            reg_we,
  input logic [VLEN-1:0] reg_data,
  input logic            st_en,
  input logic            illegal
);
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_gate_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!reg_we && !st_en));
  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !st_en);
  p_maskstore_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc == 2'd2 && form == 2'd2 && mask_en && !k0) |=> !st_en);
  p_zero_lane_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc == 2'd2 && form[1] == 1'b0 && mask_en && !k0 && zero_mask)
      |=> (reg_data[LANE-1:0] == '0));
  p_memmem_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form == 2'd3) |=> illegal);
  p_keep_hi_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc == 2'd0 && form == 2'd0)
      |=> (reg_data[VLEN-1:LANE] == $past(old_dst[VLEN-1:LANE])));
endmodule

bind msm_unit msm_unit_chk #(.VLEN(VLEN), .LANE(LANE), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .enc(enc), .form(form),
  .old_dst(old_dst), .mask_en(mask_en), .k0(k0), .zero_mask(zero_mask),
  .out_valid(out_valid), .reg_we(reg_we), .reg_data(reg_data),
  .st_en(st_en), .illegal(illegal)
);

// File: tb/sim_msm_unit.sv
module sim_msm_unit;
  localparam int VLEN = 512;
  localparam int LANE = 64;
  localparam int IDXW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] enc = '0, form = '0;
  logic [VLEN-1:0] old_dst = '0, src1 = '0, src2 = '0;
  logic [LANE-1:0] mem_in = '0;
  logic mask_en = 1'b0, k0 = 1'b0, zero_mask = 1'b0;
  logic [IDXW-1:0] idx_field = '1;
  logic out_valid, reg_we, st_en, illegal;
  logic [VLEN-1:0] reg_data;
  logic [LANE-1:0] st_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msm_unit #(.VLEN(VLEN), .LANE(LANE), .IDXW(IDXW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .enc(enc), .form(form),
    .old_dst(old_dst), .src1(src1), .src2(src2), .mem_in(mem_in),
    .mask_en(mask_en), .k0(k0), .zero_mask(zero_mask), .idx_field(idx_field),
    .out_valid(out_valid), .reg_we(reg_we), .reg_data(reg_data),
    .st_en(st_en), .st_data(st_data), .illegal(illegal)
  );

  function automatic logic [VLEN-1:0] fill(input logic [7:0] tag);
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / LANE; i++) v[i*LANE +: LANE] = {tag, 48'h0, 8'(i)};
    return v;
  endfunction

  task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ctl(input string req, input logic v, input logic we, input logic se, input logic il);
    chk(req, {{(VLEN-4){1'b0}}, out_valid, reg_we, st_en, illegal},
             {{(VLEN-4){1'b0}}, v, we, se, il});
  endtask

  // issue one operation; outputs are checked at the following negedge
  task automatic issue(input logic [1:0] e, input logic [1:0] f, input logic me,
                       input logic kk, input logic zm, input logic [IDXW-1:0] ix);
    @(negedge clk);
    enc = e; form = f; mask_en = me; k0 = kk; zero_mask = zm; idx_field = ix;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_after(input string req);
    @(negedge clk);
    chk_ctl(req, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk_ctl("R11 reset", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_base_rr;
    issue(2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 4'h0);
    chk_ctl("R1 ctl", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1/R5/R7 base reg data", reg_data, {old_dst[VLEN-1:64], src2[63:0]});
    idle_after("R10 idle after base rr");
  endtask

  task automatic t_base_load;
    issue(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 4'h3);
    chk_ctl("R2/R7 ctl", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 base load data", reg_data, {old_dst[VLEN-1:128], 64'h0, mem_in});
  endtask

  task automatic t_nds_rr;
    issue(2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 4'h2);
    chk_ctl("R3 ctl", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3/R5 nds reg data", reg_data, {{(VLEN-128){1'b0}}, src1[127:64], src2[63:0]});
  endtask

  task automatic t_nds_load;
    issue(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 4'hF);
    chk_ctl("R4 ctl", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R4 nds load data", reg_data, {{(VLEN-64){1'b0}}, mem_in});
  endtask

  task automatic t_masked_rr;
    issue(2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 4'h5);
    chk("R5 masked rr k0=1", reg_data, {{(VLEN-128){1'b0}}, src1[127:64], src2[63:0]});
    issue(2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 4'h5);
    chk("R5 masked rr merge", reg_data, {{(VLEN-128){1'b0}}, src1[127:64], old_dst[63:0]});
    chk_ctl("R5 merge ctl", 1'b1, 1'b1, 1'b0, 1'b0);
    issue(2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 4'h5);
    chk("R5 masked rr zero", reg_data, {{(VLEN-128){1'b0}}, src1[127:64], 64'h0});
  endtask

  task automatic t_masked_load;
    issue(2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 4'hF);
    chk("R4/R5 masked load zeroing", reg_data, '0);
    issue(2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 4'hF);
    chk("R5 masked load no mask", reg_data, {{(VLEN-64){1'b0}}, mem_in});
  endtask

  task automatic t_store;
    issue(2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 4'h0);
    chk_ctl("R6 base store ctl", 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 store data", {{(VLEN-64){1'b0}}, st_data}, {{(VLEN-64){1'b0}}, src2[63:0]});
    issue(2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 4'hF);
    chk_ctl("R6 masked store suppressed", 1'b1, 1'b0, 1'b0, 1'b0);
    issue(2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 4'hF);
    chk_ctl("R6 masked store k0=1", 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_illegal;
    issue(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 4'h7);
    chk_ctl("R7/R9 load bad idx", 1'b1, 1'b0, 1'b0, 1'b1);
    issue(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 4'hE);
    chk_ctl("R7/R9 store bad idx", 1'b1, 1'b0, 1'b0, 1'b1);
    issue(2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 4'hF);
    chk_ctl("R8 mem to mem", 1'b1, 1'b0, 1'b0, 1'b1);
    issue(2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF);
    chk_ctl("R8 reserved class", 1'b1, 1'b0, 1'b0, 1'b1);
    idle_after("R10 idle after illegal");
  endtask

  task automatic t_nan;
    mem_in = 64'hFFF4_0000_DEAD_BEEF;
    issue(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 4'hF);
    chk("R12 NaN load", reg_data, {{(VLEN-64){1'b0}}, 64'hFFF4_0000_DEAD_BEEF});
    mem_in = 64'h0123_4567_89AB_CDEF;
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    enc = 2'd1; form = 2'd0; in_valid = 1'b1; mask_en = 1'b0;
    @(negedge clk);
    chk("R10 first of pair", reg_data, {{(VLEN-128){1'b0}}, src1[127:64], src2[63:0]});
    chk_ctl("R10 first valid", 1'b1, 1'b1, 1'b0, 1'b0);
    enc = 2'd0; form = 2'd1; idx_field = 4'h0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second of pair", reg_data, {old_dst[VLEN-1:128], 64'h0, mem_in});
    chk_ctl("R10 second valid", 1'b1, 1'b1, 1'b0, 1'b0);
    idle_after("R10 idle after pair");
  endtask

  initial begin
    old_dst = fill(8'hA1);
    src1    = fill(8'hB2);
    src2    = fill(8'hC3);
    mem_in  = 64'h0123_4567_89AB_CDEF;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_base_rr();
    t_base_load();
    t_nds_rr();
    t_nds_load();
    t_masked_rr();
    t_masked_load();
    t_store();
    t_illegal();
    t_nan();
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule